// File: doc/BRIEF.md
# SPI Master FIFO and Status Front End

This block sits between a simple register read/write port and the serial shifter of an SPI master. It buffers outgoing bytes in a transmit queue and incoming bytes in a receive queue, each 64 bytes deep by default. Both queues are reached through one data register. A control and status register holds the link configuration (chip-select choice, clock phase and polarity, chip-select polarity, three-wire read direction). It also holds a run bit, a packed-access mode bit, two interrupt enables, two queue-flush actions and the live queue flags.

The shift engine is a separate block. It takes one byte at a time from the transmit queue through a valid/take handshake and returns each received byte through a push strobe. Software keeps the queues full and empty by polling the flags or by answering the single interrupt line. In packed mode a data access moves four bytes, least significant byte first, so a bulk mover can work with words. A programmed byte count trims the last word of a transfer.

Top module: `spi_fifo_regif`

## Requirements
- R1: After reset the control/status register (offset 0x00) reads 0x0004_0000, meaning only the transmit-room flag (bit 18) is set. The interrupt and the run output are low.
- R2: With packed mode (bit 8) clear, each data-register write (offset 0x04) queues its low byte. Each data-register read returns one received byte in bits 7:0 with zeros above, and bytes come back in the order the engine delivered them.
- R3: With packed mode set, a data write queues min(4, remaining) bytes from bits 7:0 upward. The remaining count is loaded from the length register (offset 0x0C) and counts down; a count of zero means four bytes per write. A data read pops up to four bytes into bits 7:0, 15:8, 23:16 and 31:24, and lanes with no byte read as zero.
- R4: Status bits track the queues: bit 17 is set when the receive queue holds at least one byte, bit 18 when the transmit queue has room, bit 19 when the receive queue holds at least three quarters of its depth (48), and bit 20 when the receive queue is full.
- R5: While the receive queue is full, the engine is offered no transmit byte (eng_tx_valid low), so transmission stalls until software reads.
- R6: The done flag (bit 16) is set when, with run (bit 7) high, the transmit queue becomes empty and the engine is idle. This also happens when run is raised while the queue is already empty. Writing 1 to bit 16 clears it, and it reads 0 while run is low.
- R7: Writing 1 to bit 4 empties the transmit queue and writing 1 to bit 5 empties the receive queue. Neither bit is stored, and both read back as 0.
- R8: The interrupt is high exactly when run is high and either (bit 10 set and bit 19 true) or (bit 9 set and done set).
- R9: A data write that does not fit in the transmit queue is dropped whole, and a data read of an empty receive queue returns zero. Neither case changes any other state.
- R10: Control bits 1:0, 2, 3, 6 and 12 appear on cfg_cs_sel, cfg_cpha, cfg_cpol, cfg_cs_pol and cfg_read3w and read back unchanged. The divider (offset 0x08) and length (offset 0x0C) registers read back what was written and drive cfg_div and cfg_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the data register pops |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle reg_rd is high |
| eng_run | output | 1 | Run bit to the shift engine; low returns it to idle |
| eng_tx_valid | output | 1 | A transmit byte is offered to the engine |
| eng_tx_byte | output | 8 | Offered transmit byte |
| eng_tx_take | input | 1 | Engine accepts the offered byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_busy | input | 1 | Engine is shifting a byte |
| cfg_cs_sel | output | 2 | Chip-select choice |
| cfg_cpha | output | 1 | Clock phase |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_cs_pol | output | 1 | Chip-select active level |
| cfg_read3w | output | 1 | Three-wire read direction |
| cfg_div | output | DIV_W | Serial clock divider |
| cfg_len | output | LEN_W | Programmed transfer byte count |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default depth of 64 and a 5-bit address. At that depth the three-quarter threshold of 48, the full flag and the stall all come within a few hundred cycles of a looped-back engine model. Full-queue overflow, partial last words and odd byte counts read in packed mode are driven directly. The engine model answers each byte a few cycles after taking it, so the done flag sees real busy periods between bytes.

// File: rtl/spi_fr_pkg.sv
`timescale 1ns/1ps
package spi_fr_pkg;
  // register word indices (byte address / 4)
  localparam int REG_CTRL = 0;
  localparam int REG_DATA = 1;
  localparam int REG_DIV  = 2;
  localparam int REG_LEN  = 3;

  // control/status bit positions
  localparam int B_CSSEL  = 0;
  localparam int B_CPHA   = 2;
  localparam int B_CPOL   = 3;
  localparam int B_CLRTX  = 4;
  localparam int B_CLRRX  = 5;
  localparam int B_CSPOL  = 6;
  localparam int B_RUN    = 7;
  localparam int B_WORD   = 8;
  localparam int B_IEDONE = 9;
  localparam int B_IERX   = 10;
  localparam int B_R3W    = 12;
  localparam int B_DONE   = 16;
  localparam int B_RXAV   = 17;
  localparam int B_TXRM   = 18;
  localparam int B_RXHI   = 19;
  localparam int B_RXFULL = 20;

  localparam int LANES = 4;

  typedef struct packed {
    logic       read3w;
    logic       ie_rx;
    logic       ie_done;
    logic       word_mode;
    logic       run;
    logic       cs_pol;
    logic       cpol;
    logic       cpha;
    logic [1:0] cs_sel;
  } ctrl_t;
endpackage

// File: rtl/spi_fr_fifo.sv
`timescale 1ns/1ps
// Byte queue with several push lanes and several peek lanes per cycle.
// DEPTH must be a power of two; callers never push beyond free space
// nor pop beyond the level.
module spi_fr_fifo #(
  parameter int DEPTH  = 64,
  parameter int PUSH_W = 1,
  parameter int POP_W  = 1,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic [CW-1:0]       push_n,
  input  logic [PUSH_W*8-1:0] push_data,
  input  logic [CW-1:0]       pop_n,
  output logic [POP_W*8-1:0]  peek_data,
  output logic [CW-1:0]       level
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] level_q, level_d;
  logic [7:0]    mem [DEPTH];

  always_comb begin
    if (clear) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      wr_ptr_d = wr_ptr_q + AW'(push_n);
      rd_ptr_d = rd_ptr_q + AW'(pop_n);
      level_d  = level_q + push_n - pop_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_W; i++) begin
      if (!clear && (CW'(i) < push_n))
        mem[wr_ptr_q + AW'(i)] <= push_data[i*8 +: 8];
    end
  end

  for (genvar g = 0; g < POP_W; g++) begin : g_peek
    assign peek_data[g*8 +: 8] = mem[rd_ptr_q + AW'(g)];
  end

  assign level = level_q;
endmodule

// File: rtl/spi_fr_status.sv
`timescale 1ns/1ps
// Queue flags, the sticky done flag and the interrupt line.
module spi_fr_status #(
  parameter int DEPTH = 64,
  parameter int RX_HI = 48,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  input  logic          eng_busy,
  input  logic          done_ack,
  input  logic          ie_done,
  input  logic          ie_rx,
  output logic          done,
  output logic          rx_avail,
  output logic          tx_room,
  output logic          rx_hi,
  output logic          rx_full,
  output logic          irq
);
  logic drain_now, drain_q;
  logic done_q, done_d;

  assign drain_now = run && (tx_level == '0) && !eng_busy;

  // a fresh drain event wins over a simultaneous acknowledge
  always_comb begin
    if (!run)                      done_d = 1'b0;
    else if (drain_now && !drain_q) done_d = 1'b1;
    else if (done_ack)             done_d = 1'b0;
    else                           done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      drain_q <= drain_now;
      done_q  <= done_d;
    end
  end

  assign done     = done_q;
  assign rx_avail = (rx_level != '0);
  assign tx_room  = (tx_level != CW'(DEPTH));
  assign rx_hi    = (rx_level >= CW'(RX_HI));
  assign rx_full  = (rx_level == CW'(DEPTH));
  assign irq      = run && ((ie_rx && rx_hi) || (ie_done && done_q));
endmodule

// File: rtl/spi_fifo_regif.sv
`timescale 1ns/1ps
module spi_fifo_regif
  import spi_fr_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_run,
  output logic              eng_tx_valid,
  output logic [7:0]        eng_tx_byte,
  input  logic              eng_tx_take,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_byte,
  input  logic              eng_busy,
  output logic [1:0]        cfg_cs_sel,
  output logic              cfg_cpha,
  output logic              cfg_cpol,
  output logic              cfg_cs_pol,
  output logic              cfg_read3w,
  output logic [DIV_W-1:0]  cfg_div,
  output logic [LEN_W-1:0]  cfg_len,
  output logic              irq
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int SEL_W = ADDR_W - 2;
  localparam int RX_HI = (DEPTH * 3) / 4;

  // ---------------- register decode
  logic [SEL_W-1:0] sel;
  logic wr_ctrl, wr_data, wr_div, wr_len, rd_data;
  logic clr_tx, clr_rx, done_ack;

  assign sel      = reg_addr[ADDR_W-1:2];
  assign wr_ctrl  = reg_wr && (int'(sel) == REG_CTRL);
  assign wr_data  = reg_wr && (int'(sel) == REG_DATA);
  assign wr_div   = reg_wr && (int'(sel) == REG_DIV);
  assign wr_len   = reg_wr && (int'(sel) == REG_LEN);
  assign rd_data  = reg_rd && (int'(sel) == REG_DATA);
  assign clr_tx   = wr_ctrl && reg_wdata[B_CLRTX];
  assign clr_rx   = wr_ctrl && reg_wdata[B_CLRRX];
  assign done_ack = wr_ctrl && reg_wdata[B_DONE];

  // ---------------- stored registers
  ctrl_t             ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  left_q, left_d;

  // ---------------- queues
  logic [CW-1:0]         tx_level, rx_level;
  logic [CW-1:0]         tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [7:0]            tx_peek;
  logic [LANES*8-1:0]    rx_peek, rx_word;
  logic [CW-1:0]         tx_free;
  logic [2:0]            wcount, rcount;
  logic                  tx_accept;

  // bytes carried by one data write
  always_comb begin
    if (!ctrl_q.word_mode)                               wcount = 3'd1;
    else if (left_q == '0 || left_q >= LEN_W'(LANES))    wcount = 3'd4;
    else                                                 wcount = 3'(left_q);
  end

  // bytes returned by one data read
  always_comb begin
    if (rx_level == '0)                  rcount = 3'd0;
    else if (!ctrl_q.word_mode)          rcount = 3'd1;
    else if (rx_level >= CW'(LANES))     rcount = 3'd4;
    else                                 rcount = 3'(rx_level);
  end

  assign tx_free      = CW'(DEPTH) - tx_level;
  assign tx_accept    = wr_data && (CW'(wcount) <= tx_free);
  assign tx_push_n    = tx_accept ? CW'(wcount) : '0;
  assign eng_tx_valid = ctrl_q.run && (tx_level != '0) && (rx_level != CW'(DEPTH));
  assign eng_tx_byte  = tx_peek;
  assign tx_pop_n     = (eng_tx_valid && eng_tx_take) ? CW'(1) : '0;
  assign rx_push_n    = (eng_rx_push && rx_level != CW'(DEPTH)) ? CW'(1) : '0;
  assign rx_pop_n     = rd_data ? CW'(rcount) : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_rx_lane
    assign rx_word[g*8 +: 8] = (3'(g) < rcount) ? rx_peek[g*8 +: 8] : 8'h00;
  end

  spi_fr_fifo #(.DEPTH(DEPTH), .PUSH_W(LANES), .POP_W(1), .CW(CW)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clr_tx),
    .push_n    (tx_push_n),
    .push_data (reg_wdata),
    .pop_n     (tx_pop_n),
    .peek_data (tx_peek),
    .level     (tx_level)
  );

  spi_fr_fifo #(.DEPTH(DEPTH), .PUSH_W(1), .POP_W(LANES), .CW(CW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clr_rx),
    .push_n    (rx_push_n),
    .push_data (eng_rx_byte),
    .pop_n     (rx_pop_n),
    .peek_data (rx_peek),
    .level     (rx_level)
  );

  // ---------------- status and interrupt
  logic done, rx_avail, tx_room, rx_hi, rx_full;

  spi_fr_status #(.DEPTH(DEPTH), .RX_HI(RX_HI), .CW(CW)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_q.run),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .eng_busy (eng_busy),
    .done_ack (done_ack),
    .ie_done  (ctrl_q.ie_done),
    .ie_rx    (ctrl_q.ie_rx),
    .done     (done),
    .rx_avail (rx_avail),
    .tx_room  (tx_room),
    .rx_hi    (rx_hi),
    .rx_full  (rx_full),
    .irq      (irq)
  );

  // ---------------- next state of the stored registers
  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    len_d  = len_q;
    left_d = left_q;
    if (wr_ctrl) begin
      ctrl_d.cs_sel    = reg_wdata[B_CSSEL +: 2];
      ctrl_d.cpha      = reg_wdata[B_CPHA];
      ctrl_d.cpol      = reg_wdata[B_CPOL];
      ctrl_d.cs_pol    = reg_wdata[B_CSPOL];
      ctrl_d.run       = reg_wdata[B_RUN];
      ctrl_d.word_mode = reg_wdata[B_WORD];
      ctrl_d.ie_done   = reg_wdata[B_IEDONE];
      ctrl_d.ie_rx     = reg_wdata[B_IERX];
      ctrl_d.read3w    = reg_wdata[B_R3W];
    end
    if (wr_div) div_d = reg_wdata[DIV_W-1:0];
    if (wr_len) begin
      len_d  = reg_wdata[LEN_W-1:0];
      left_d = reg_wdata[LEN_W-1:0];
    end else if (tx_accept && ctrl_q.word_mode && left_q != '0) begin
      left_d = left_q - LEN_W'(wcount);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      len_q  <= '0;
      left_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      len_q  <= len_d;
      left_q <= left_d;
    end
  end

  // ---------------- read mux
  logic [31:0] ctrl_rd;
  always_comb begin
    ctrl_rd                  = '0;
    ctrl_rd[B_CSSEL +: 2]    = ctrl_q.cs_sel;
    ctrl_rd[B_CPHA]          = ctrl_q.cpha;
    ctrl_rd[B_CPOL]          = ctrl_q.cpol;
    ctrl_rd[B_CSPOL]         = ctrl_q.cs_pol;
    ctrl_rd[B_RUN]           = ctrl_q.run;
    ctrl_rd[B_WORD]          = ctrl_q.word_mode;
    ctrl_rd[B_IEDONE]        = ctrl_q.ie_done;
    ctrl_rd[B_IERX]          = ctrl_q.ie_rx;
    ctrl_rd[B_R3W]           = ctrl_q.read3w;
    ctrl_rd[B_DONE]          = done;
    ctrl_rd[B_RXAV]          = rx_avail;
    ctrl_rd[B_TXRM]          = tx_room;
    ctrl_rd[B_RXHI]          = rx_hi;
    ctrl_rd[B_RXFULL]        = rx_full;
  end

  always_comb begin
    case (int'(sel))
      REG_CTRL: reg_rdata = ctrl_rd;
      REG_DATA: reg_rdata = rx_word;
      REG_DIV:  reg_rdata = 32'(div_q);
      REG_LEN:  reg_rdata = 32'(len_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign eng_run    = ctrl_q.run;
  assign cfg_cs_sel = ctrl_q.cs_sel;
  assign cfg_cpha   = ctrl_q.cpha;
  assign cfg_cpol   = ctrl_q.cpol;
  assign cfg_cs_pol = ctrl_q.cs_pol;
  assign cfg_read3w = ctrl_q.read3w;
  assign cfg_div    = div_q;
  assign cfg_len    = len_q;
endmodule

// File: rtl/spi_fifo_regif_chk.sv
`timescale 1ns/1ps
module spi_fifo_regif_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] rx_pop_n,
  input logic          wr_ctrl,
  input logic [31:0]   wdata,
  input logic          done
);
  // R9: overflowing writes are dropped, so the transmit level stays in range
  a_r9_tx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CW'(DEPTH));

  // R4: receive level never passes the full mark
  a_r4_rx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CW'(DEPTH));

  // R5: with the receive queue full and nothing read, transmit does not drain
  a_r5_stall_holds_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == CW'(DEPTH) && rx_pop_n == '0 && !wr_ctrl)
      |=> tx_level >= $past(tx_level));

  // R7: flush actions empty their queue on the next cycle
  a_r7_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[4]) |=> tx_level == '0);
  a_r7_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[5]) |=> rx_level == '0);

  // R6: done never survives a cycle with run low
  a_r6_done_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);
endmodule

bind spi_fifo_regif spi_fifo_regif_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (eng_run),
  .tx_level (tx_level),
  .rx_level (rx_level),
  .rx_pop_n (rx_pop_n),
  .wr_ctrl  (wr_ctrl),
  .wdata    (reg_wdata),
  .done     (done)
);

// File: tb/test_spi_fifo_regif.sv
`timescale 1ns/1ps
module test_spi_fifo_regif;
  localparam int DEPTH = 64;
  localparam int ADDR_W = 5;

  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        eng_run, eng_tx_valid, eng_tx_take, eng_rx_push, eng_busy;
  logic [7:0]  eng_tx_byte, eng_rx_byte;
  logic [1:0]  cfg_cs_sel;
  logic        cfg_cpha, cfg_cpol, cfg_cs_pol, cfg_read3w, irq;
  logic [15:0] cfg_div, cfg_len;

  spi_fifo_regif #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_spi_fifo_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_run(eng_run), .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
    .eng_tx_take(eng_tx_take), .eng_rx_push(eng_rx_push),
    .eng_rx_byte(eng_rx_byte), .eng_busy(eng_busy),
    .cfg_cs_sel(cfg_cs_sel), .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol),
    .cfg_cs_pol(cfg_cs_pol), .cfg_read3w(cfg_read3w), .cfg_div(cfg_div),
    .cfg_len(cfg_len), .irq(irq)
  );

  initial begin clk = 1'b0; forever #10 clk = ~clk; end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // control word values
  localparam logic [31:0] C_RUN = 32'h80, C_WORD = 32'h100, C_IED = 32'h200,
                          C_IER = 32'h400, C_CLRT = 32'h10, C_CLRR = 32'h20,
                          C_DONE = 32'h1_0000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected flags {full, three-quarter, tx room, rx avail, done}
  function automatic logic [31:0] flags(input int rxn, input int txn, input bit dn);
    return {27'd0, rxn == DEPTH, rxn >= (DEPTH * 3) / 4, txn < DEPTH, rxn > 0, dn};
  endfunction

  task automatic wr(input int ofs, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_W'(ofs * 4); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ofs, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = ADDR_W'(ofs * 4);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // loopback engine model: takes a byte, returns it three cycles later
  bit eng_on = 0;
  initial begin
    int pend;
    logic [7:0] held;
    pend = 0; held = 8'h00;
    eng_tx_take = 0; eng_rx_push = 0; eng_busy = 0; eng_rx_byte = 8'h00;
    forever begin
      @(negedge clk);
      eng_tx_take = 1'b0;
      eng_rx_push = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          eng_rx_push = 1'b1; eng_rx_byte = held; eng_busy = 1'b0;
        end
      end else if (eng_on && eng_run && eng_tx_valid && !eng_busy) begin
        eng_tx_take = 1'b1; held = eng_tx_byte; eng_busy = 1'b1; pend = 3;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  bq[$];
    logic [31:0] wq[$];
    void'($urandom(32'd20240611));
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0; rst_n = 0;
    waitc(5);
    rst_n = 1;
    waitc(2);

    // R1 reset state
    rd(0, d);
    chk("R1 ctrl after reset", d, 32'h0004_0000);
    chk("R1 irq after reset", {31'd0, irq}, 0);
    chk("R1 run after reset", {31'd0, eng_run}, 0);

    // R10 configuration fields
    wr(0, 32'h2 | 32'h4 | 32'h8 | 32'h40 | 32'h1000);
    chk("R10 cs_sel", {30'd0, cfg_cs_sel}, 2);
    chk("R10 cpha/cpol/cspol/3w", {28'd0, cfg_cpha, cfg_cpol, cfg_cs_pol, cfg_read3w}, 32'hF);
    rd(0, d);
    chk("R10 ctrl readback", d & 32'hFFFF, 32'h104E);
    wr(2, 32'h1234); wr(3, 32'hABCD);
    rd(2, d); chk("R10 divider readback", d, 32'h1234);
    rd(3, d); chk("R10 length readback", d, 32'hABCD);
    chk("R10 cfg_div/cfg_len", {cfg_div, cfg_len}, 32'h1234_ABCD);
    wr(0, 0); wr(3, 0);

    // R9 overflow with run low, then loop through engine
    eng_on = 1;
    for (int i = 0; i < 65; i++) wr(1, 32'(i ^ 8'h3C));
    rd(0, d); chk("R9 tx full drops, flags", d[20:16], flags(0, 64, 0));
    wr(0, C_RUN);
    waitc(64 * 5 + 40);
    rd(0, d); chk("R4 rx full flags", d[20:16], flags(64, 0, 1));
    for (int i = 0; i < 64; i++) begin
      rd(1, d); chk("R2 byte order", d, 32'((i ^ 8'h3C) & 8'hFF));
    end
    rd(1, d); chk("R9 empty read is zero", d, 0);
    rd(0, d); chk("R4 flags after drain", d[20:16], flags(0, 0, 1));

    // R5 stall and R8 rx-level interrupt, then R7 flush
    wr(0, C_RUN | C_IER);
    for (int i = 0; i < 64; i++) wr(1, 32'((i * 7) & 8'hFF));
    waitc(64 * 5 + 40);
    chk("R8 irq on rx level", {31'd0, irq}, 1);
    rd(0, d); chk("R4 three-quarter and full", d[20:19], 2'b11);
    for (int i = 0; i < 3; i++) wr(1, 32'(8'hE0 + i));
    waitc(40);
    chk("R5 no byte offered while rx full", {31'd0, eng_tx_valid}, 0);
    rd(0, d); chk("R5 flags while stalled", d[20:16], flags(64, 3, 1));
    rd(1, d); chk("R5 first byte", d, 0);
    waitc(20);
    chk("R5 stalls again after one slot", {31'd0, eng_tx_valid}, 0);
    rd(0, d); chk("R5 refilled to full", d[20:20], 1);
    wr(0, C_RUN | C_IER | C_CLRT | C_CLRR);
    waitc(3);
    rd(0, d);
    chk("R7 clear bits read zero", d[5:4], 0);
    chk("R7 queues empty", d[20:16], flags(0, 0, 1));
    chk("R8 irq low after flush", {31'd0, irq}, 0);
    rd(1, d); chk("R7 rx empty after flush", d, 0);

    // R6 done flag and R8 done interrupt
    wr(0, 0); waitc(2);
    rd(0, d); chk("R6 done low with run low", d[16], 0);
    wr(0, C_RUN | C_IED); waitc(2);
    rd(0, d); chk("R6 done on run with empty tx", d[16], 1);
    chk("R8 irq on done", {31'd0, irq}, 1);
    wr(0, C_RUN | C_IED | C_DONE); waitc(2);
    rd(0, d); chk("R6 done cleared by write-one", d[16], 0);
    chk("R8 irq low after ack", {31'd0, irq}, 0);
    wr(1, 32'h5A); wr(1, 32'hC3); waitc(30);
    rd(0, d); chk("R6 done after drain", d[16], 1);
    chk("R8 irq after drain", {31'd0, irq}, 1);
    wr(0, 0); waitc(2);
    chk("R8 irq gated by run", {31'd0, irq}, 0);
    rd(1, d); chk("R2 byte 0", d, 32'h5A);
    rd(1, d); chk("R2 byte 1", d, 32'hC3);

    // R3 packed mode with a trimmed final word
    wr(0, C_RUN | C_WORD); wr(3, 6);
    wr(1, 32'h4433_2211); wr(1, 32'hEEFF_6655);
    waitc(60);
    rd(1, d); chk("R3 packed word", d, 32'h4433_2211);
    rd(1, d); chk("R3 trimmed word", d, 32'h0000_6655);
    rd(1, d); chk("R3 empty packed read", d, 0);
    wr(0, C_RUN);
    wr(1, 32'hAA); wr(1, 32'hBB); wr(1, 32'hCC);
    waitc(30);
    wr(0, C_RUN | C_WORD);
    rd(1, d); chk("R3 partial packed read", d, 32'h00CC_BBAA);
    wr(3, 0);
    for (int r = 0; r < 3; r++) begin
      int nw;
      nw = 1 + int'($urandom % 10);
      wq.delete();
      for (int i = 0; i < nw; i++) begin
        wq.push_back($urandom);
        wr(1, wq[i]);
      end
      waitc(nw * 4 * 6 + 30);
      for (int i = 0; i < nw; i++) begin
        rd(1, d); chk("R3 random packed word", d, wq[i]);
      end
    end

    // R2 random byte streams
    wr(0, C_RUN);
    for (int r = 0; r < 6; r++) begin
      int nb;
      nb = 1 + int'($urandom % 40);
      bq.delete();
      for (int i = 0; i < nb; i++) begin
        bq.push_back(8'($urandom));
        wr(1, {$urandom, bq[i]} >> 0 & 32'hFFFF_FF00 | 32'(bq[i]));
      end
      waitc(nb * 6 + 30);
      for (int i = 0; i < nb; i++) begin
        rd(1, d); chk("R2 random byte", d, 32'(bq[i]));
      end
      rd(1, d); chk("R9 empty after stream", d, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule